// File: doc/BRIEF.md
# Programmable-Resolution Tracking Angle Counter

This block holds the digital shaft angle of a tracking converter as a 16-bit binary fraction of a full turn. The top bit stands for half a turn. An upstream rate generator sends single-cycle increment and decrement pulses. Each pulse moves the angle by one least-significant bit of the resolution currently in force. The resolution can be 10, 12, 14 or 16 bits. The count wraps freely around the full turn in both directions.

The resolution code on the input pins may change at any time, including while pulses are arriving. The block keeps its own copy of the code in force and takes a new code only on a cycle with no count pulse. A pulse that arrives together with a code change is therefore applied at the old step size. When a coarser resolution is taken, the angle bits below the new least-significant bit are cleared. The word then always lies on the grid of the resolution in force.

Top module: `trk_angle_counter`

## Requirements
- R1: A synchronous reset, with `rst` high at a clock edge, sets the angle to zero and puts 16-bit mode in force, whatever `resSel` holds.
- R2: An increment pulse alone adds the step of the resolution in force. The steps are 64 for code 00 (10-bit), 16 for code 01 (12-bit), 4 for code 10 (14-bit) and 1 for code 11 (16-bit).
- R3: A decrement pulse alone subtracts the step of the resolution in force.
- R4: Counting up wraps modulo 2^16. In 10-bit mode, 0xFFC0 plus one increment gives 0x0000.
- R5: Counting down wraps modulo 2^16. From 0x0000, a decrement gives 0xFFFF in 16-bit mode and 0xFFC0 in 10-bit mode.
- R6: If increment and decrement are both high in one cycle, the angle is unchanged and no new resolution is taken in that cycle.
- R7: A new `resSel` value is taken only on a cycle where both pulse inputs are low. A pulse in the same cycle as a code change moves the angle by the old step.
- R8: On the cycle a new resolution is taken, the angle bits below that resolution's least-significant bit are cleared. The remaining bits are kept.
- R9: With no pulse and `resSel` equal to the code in force, the angle holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| incPulse | input | 1 | One-cycle request to count up one step |
| decPulse | input | 1 | One-cycle request to count down one step |
| resSel | input | 2 | Requested resolution code (00=10, 01=12, 10=14, 11=16 bits) |
| angle | output | 16 | Current angle, natural binary, MSB = 180 degrees |

## Verification
The resolution in force is internal, so a wrong latched code shows only through the step size of the next lone pulse, or through low bits that are not cleared on an adoption. Each such fault appears on `angle` one edge after the pulse or the adoption. The checks therefore follow every code change with counting, and they place code changes in the same cycle as pulses and as cancelling pulse pairs. A wraparound fault shows on the single edge that crosses zero, so both crossing directions are driven at coarse and fine steps.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int RES_W = 2;
  localparam int NUM_CODES = 2 ** RES_W;
  // Step exponent spread between finest and coarsest resolution
  localparam int SHIFT_SPAN = 2 * (NUM_CODES - 1);

  typedef struct packed {
    logic             countEn;
    logic             countDown;
    logic             adopt;
    logic [RES_W-1:0] newRes;
  } trkStrobe_t;
endpackage

// File: rtl/trk_ctrl.sv
module trk_ctrl
  import trk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             incPulse,
  input  logic             decPulse,
  input  logic [RES_W-1:0] resSel,
  output trkStrobe_t       strobe,
  output logic [RES_W-1:0] activeRes
);
  logic pulsePending;

  always_comb begin
    pulsePending     = incPulse | decPulse;
    strobe.countEn   = incPulse ^ decPulse;
    strobe.countDown = decPulse;
    strobe.adopt     = !pulsePending && (resSel != activeRes);
    strobe.newRes    = resSel;
  end

  always_ff @(posedge clk) begin
    if (rst)               activeRes <= '1;
    else if (strobe.adopt) activeRes <= strobe.newRes;
  end
endmodule

// File: rtl/trk_datapath.sv
module trk_datapath
  import trk_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  trkStrobe_t         strobe,
  input  logic [RES_W-1:0]   activeRes,
  output logic [ANGLE_W-1:0] angle
);
  localparam logic [ANGLE_W-1:0] ONE = {{(ANGLE_W-1){1'b0}}, 1'b1};

  logic [ANGLE_W-1:0] stepOf [NUM_CODES];
  logic [ANGLE_W-1:0] keepOf [NUM_CODES];
  logic [ANGLE_W-1:0] curStep;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    localparam int SHIFT = SHIFT_SPAN - 2 * c;
    assign stepOf[c] = ONE << SHIFT;
    assign keepOf[c] = ~((ONE << SHIFT) - ONE);
  end

  assign curStep = stepOf[activeRes];

  always_ff @(posedge clk) begin
    if (rst)                 angle <= '0;
    else if (strobe.countEn) angle <= strobe.countDown ? angle - curStep : angle + curStep;
    else if (strobe.adopt)   angle <= angle & keepOf[strobe.newRes];
  end
endmodule

// File: rtl/trk_angle_counter.sv
module trk_angle_counter
  import trk_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               incPulse,
  input  logic               decPulse,
  input  logic [1:0]         resSel,
  output logic [ANGLE_W-1:0] angle
);
  trkStrobe_t       strobe;
  logic [RES_W-1:0] activeRes;

  trk_ctrl i_ctrl (
    .clk(clk), .rst(rst), .incPulse(incPulse), .decPulse(decPulse),
    .resSel(resSel), .strobe(strobe), .activeRes(activeRes)
  );

  trk_datapath #(.ANGLE_W(ANGLE_W)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .activeRes(activeRes), .angle(angle)
  );
endmodule

// File: rtl/trk_angle_counter_chk.sv
module trk_angle_counter_chk #(
  parameter int ANGLE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               incPulse,
  input logic               decPulse,
  input logic [1:0]         resSel,
  input logic [ANGLE_W-1:0] angle
);
  // Resolution in force, tracked from the ports alone
  logic [1:0] seenRes;
  always_ff @(posedge clk) begin
    if (rst)                                          seenRes <= 2'b11;
    else if (!incPulse && !decPulse && resSel != seenRes) seenRes <= resSel;
  end

  function automatic logic [ANGLE_W-1:0] stepFor(input logic [1:0] code);
    return ANGLE_W'(1) << (6 - 2 * int'(code));
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> angle == '0);

  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (incPulse && !decPulse) |=> angle == ANGLE_W'($past(angle) + stepFor($past(seenRes))));

  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (decPulse && !incPulse) |=> angle == ANGLE_W'($past(angle) - stepFor($past(seenRes))));

  p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    (incPulse && decPulse) |=> $stable(angle));

  p_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    (angle & (stepFor(seenRes) - ANGLE_W'(1))) == '0);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!incPulse && !decPulse && resSel == seenRes) |=> $stable(angle));
endmodule

bind trk_angle_counter trk_angle_counter_chk #(.ANGLE_W(ANGLE_W)) i_chk (.*);

// File: tb/test_trk_angle_counter.sv
module test_trk_angle_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        incPulse = 1'b0;
  logic        decPulse = 1'b0;
  logic [1:0]  resSel = 2'b00;
  logic [15:0] angle;

  always #2 clk = ~clk;

  trk_angle_counter i_trk_angle_counter (
    .clk(clk), .rst(rst), .incPulse(incPulse), .decPulse(decPulse),
    .resSel(resSel), .angle(angle)
  );

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0;
  int fails = 0;
  logic [1:0]  mRes = 2'b11;
  logic [15:0] mAngle = 16'h0;
  bit done = 0;

  // Driver: applies one cycle of stimulus and queues the angle expected after the edge
  task automatic drive(input logic r, input logic i, input logic d,
                       input logic [1:0] s, input string tag);
    logic [15:0] st;
    @(negedge clk);
    rst = r; incPulse = i; decPulse = d; resSel = s;
    if (r) begin
      mAngle = 16'h0; mRes = 2'b11;
    end else if (i ^ d) begin
      st = 16'(1) << (6 - 2 * int'(mRes));
      mAngle = d ? mAngle - st : mAngle + st;
    end else if (!i && !d && s != mRes) begin
      mRes = s;
      mAngle = mAngle & ~((16'(1) << (6 - 2 * int'(s))) - 16'(1));
    end
    q.push_back('{mAngle, tag});
  endtask

  // Monitor: compares after each edge
  initial forever begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (angle !== it.exp) begin
        fails++;
        $display("FAIL %s: angle=%h expected=%h", it.tag, angle, it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset clears, 16-bit mode in force despite resSel=00
    drive(1, 0, 0, 2'b00, "R1");
    drive(1, 0, 0, 2'b00, "R1");
    drive(0, 1, 0, 2'b00, "R1 16-bit step / R7 old step");  // 0x0001
    drive(0, 0, 1, 2'b11, "R3");                            // 0x0000
    drive(0, 0, 1, 2'b11, "R5 wrap 16-bit");                // 0xFFFF
    drive(0, 0, 1, 2'b11, "R3");                            // 0xFFFE
    drive(0, 0, 0, 2'b01, "R8 clear to 12-bit");            // 0xFFF0
    drive(0, 1, 0, 2'b01, "R4 wrap 12-bit");                // 0x0000
    drive(0, 1, 0, 2'b01, "R2 12-bit step");                // 0x0010
    drive(0, 0, 1, 2'b01, "R3");                            // 0x0000
    drive(0, 0, 1, 2'b01, "R5 wrap 12-bit");                // 0xFFF0
    drive(0, 1, 1, 2'b00, "R6 cancel");                     // 0xFFF0
    drive(0, 1, 0, 2'b00, "R7 old step after cancel");      // 0x0000
    drive(0, 0, 0, 2'b00, "R7 adopt 10-bit");               // 0x0000
    drive(0, 1, 0, 2'b00, "R2 10-bit step");                // 0x0040
    drive(0, 0, 0, 2'b10, "R8 adopt 14-bit");               // 0x0040
    drive(0, 1, 0, 2'b10, "R2 14-bit step");                // 0x0044
    drive(0, 0, 0, 2'b00, "R8 clear to 10-bit");            // 0x0040
    drive(0, 0, 1, 2'b00, "R3 10-bit");                     // 0x0000
    drive(0, 0, 1, 2'b00, "R5 wrap 10-bit");                // 0xFFC0
    drive(0, 1, 0, 2'b00, "R4 wrap 10-bit");                // 0x0000
    drive(0, 0, 0, 2'b00, "R9 hold");
    drive(0, 0, 0, 2'b00, "R9 hold");
    for (int k = 0; k < 300; k++) begin
      logic [3:0] rv;
      rv = 4'($urandom_range(0, 15));
      drive(0, rv[0], rv[1], rv[3:2], "R7 mixed");
    end
    drive(1, 1, 0, 2'b01, "R1 reset mid-run");
    drive(0, 1, 0, 2'b01, "R1 16-bit after reset");         // 0x0001
    drive(0, 0, 0, 2'b11, "R9 hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule